// File: doc/BRIEF.md
# G.711 Companding Codec

This block converts between 16-bit two's-complement linear voice samples and 8-bit companded codes for one 64 kb/s channel. At an 8 kHz sample rate that is one code each 125 µs. The encoder compresses a linear sample into a code. The decoder expands a code back into the linear value at the centre of its quantization step. Each direction has a one-cycle valid strobe and a registered result.

Two curves are available: A-law and µ-law. The effective curve is the logical OR of a configuration register bit and an external pin, and a value of 1 selects A-law. The code assignment is also selectable. The line form flips a fixed bit pattern over a raw sign/segment/mantissa byte. The sign-magnitude form emits that raw byte unchanged. The configuration register holds the law bit and the coding bit. It is written with a single-cycle write strobe and clears to µ-law with line coding on reset.

The block has no state machine. Each direction is a combinational datapath feeding one output register, and the configuration is a two-bit register.

Top module: `g711_codec`

## Requirements
- R1: After reset, the configuration selects µ-law with line coding, both output valids are 0 and both output data registers are 0. In this state a linear 0 encodes to 8'hFF.
- R2: The effective law is cfg law bit OR `law_pin`, where 1 means A-law. With the register bit at 0 and the pin at 1, a linear 0 encodes to 8'hD5.
- R3: µ-law encoding works as follows. The value is lin>>>2, taken as 14 bits. Its magnitude is that value for non-negative inputs and its one's complement for negative ones. The magnitude saturates at 8158, and 33 is then added. The segment is (msb position − 5), where msb position 5 gives segment 0, and the mantissa is the four bits below the msb. Examples: 16'h7FFF→8'h80, 16'h8000→8'h00, 16'h7F7C→8'h80, 1000→8'hCE.
- R4: A-law encoding works as follows. The value is lin>>>3, taken as 13 bits. The magnitude is formed the same way as in R3. When the magnitude is below 32, the segment is 0 and the mantissa is mag[4:1]. Otherwise the segment is (msb position − 4) and the mantissa is the four bits below the msb. Examples: 16'h7FFF→8'hAA, 16'h8000→8'h2A, 1000→8'hFA.
- R5: The raw byte is {positive, segment[2:0], mantissa[3:0]}, where bit 7 = 1 for a non-negative sample. In line coding, A-law emits raw XOR 8'h55 (e.g. 0→8'hD5, −1→8'h55).
- R6: In line coding, µ-law emits raw XOR 8'h7F (e.g. 0→8'hFF, −1→8'h7F).
- R7: In sign-magnitude coding, the raw byte is emitted unchanged for either law (0→8'h80, A-law 1000→8'hAF).
- R8: Decoding first removes the mode's pattern to recover the raw byte. For A-law, the magnitude is {mant,4'h8} in segment 0. In segment s ≥ 1 it is {1,mant,4'h8}<<(s−1). For µ-law, the magnitude is (({mant,3'b0}+132)<<s)−132. A raw bit 7 of 0 negates the magnitude. Examples: µ line 8'h80→32124, µ line 8'h00→−32124, A line 8'hAA→32256, A line 8'hD5→8, A sign-magnitude 8'h00→−8, µ sign-magnitude 8'hB1→988.
- R9: `enc_valid_o` is high exactly in the cycle after an `enc_valid_i` cycle. `enc_code_o` changes only after a valid input.
- R10: `dec_valid_o` is high exactly in the cycle after a `dec_valid_i` cycle. `dec_lin_o` changes only after a valid input.
- R11: For every law and coding combination and every code c, encoding the decode of c returns c. The one exception is µ-law raw 8'h00 (negative zero), which returns the code of raw 8'h80.
- R12: A configuration write acts on samples presented in later cycles. A sample presented in the same cycle as the write still uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_law_d | input | 1 | Law bit to write (1 = A-law) |
| cfg_smag_d | input | 1 | Coding bit to write (1 = sign-magnitude) |
| law_pin | input | 1 | External law select, ORed with the register bit |
| enc_valid_i | input | 1 | Linear sample valid |
| enc_lin_i | input | 16 | Linear sample, two's complement |
| enc_valid_o | output | 1 | Compressed code valid |
| enc_code_o | output | 8 | Compressed code |
| dec_valid_i | input | 1 | Compressed code valid |
| dec_code_i | input | 8 | Compressed code |
| dec_valid_o | output | 1 | Expanded sample valid |
| dec_lin_o | output | 16 | Expanded linear sample |

## Verification
The hardest situations to reach from the ports are the rare code points. Examples are the µ-law negative-zero code and the saturation edge just above the top µ-law segment. Another is the cycle in which a configuration write and a sample arrive together. The bench reaches every code point by decoding each of the 256 codes in all four law/coding settings and feeding each result straight back into the encoder. It targets the write/sample collision with a directed sequence that raises both strobes on the same edge.

// File: rtl/g711_pkg.sv
package g711_pkg;
    localparam int LIN_W    = 16;
    localparam int CODE_W   = 8;
    localparam int A_MAG_W  = 12;
    localparam int MU_MAG_W = 13;

    localparam logic [CODE_W-1:0]   A_LINE_MASK  = 8'h55;
    localparam logic [CODE_W-1:0]   MU_LINE_MASK = 8'h7F;
    localparam logic [MU_MAG_W-1:0] MU_CLIP      = 13'd8158;
    localparam logic [MU_MAG_W-1:0] MU_BIAS      = 13'd33;
    localparam logic [LIN_W-1:0]    MU_DEC_BIAS  = 16'h0084;

    typedef enum logic {
        LAW_MU = 1'b0,
        LAW_A  = 1'b1
    } law_e;

    function automatic logic [CODE_W-1:0] code_mask(input law_e law, input logic smag);
        if (smag)
            return '0;
        return (law == LAW_A) ? A_LINE_MASK : MU_LINE_MASK;
    endfunction
endpackage

// File: rtl/g711_cfg_reg.sv
module g711_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic law_d,
    input  logic smag_d,
    output logic law_q,
    output logic smag_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            law_q  <= 1'b0;
            smag_q <= 1'b0;
        end else if (we) begin
            law_q  <= law_d;
            smag_q <= smag_d;
        end
    end
endmodule

// File: rtl/g711_encoder.sv
module g711_encoder
    import g711_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              law_a,
    input  logic              smag,
    input  logic              valid_i,
    input  logic [LIN_W-1:0]  lin_i,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o
);
    logic                pos;
    logic [A_MAG_W-1:0]  a_mag;
    logic [MU_MAG_W-1:0] mu_mag;
    logic [MU_MAG_W-1:0] mu_val;
    logic [2:0]          a_seg, mu_seg;
    logic [3:0]          a_mant, mu_mant;
    logic [CODE_W-1:0]   raw;
    logic [CODE_W-1:0]   code_d;
    logic                unused_lsb;

    assign unused_lsb = ^lin_i[1:0];
    assign pos = ~lin_i[LIN_W-1];

    // Magnitudes: one's complement for negative inputs keeps full scale in range
    always_comb begin
        a_mag  = pos ? lin_i[LIN_W-2 -: A_MAG_W]  : ~lin_i[LIN_W-2 -: A_MAG_W];
        mu_mag = pos ? lin_i[LIN_W-2 -: MU_MAG_W] : ~lin_i[LIN_W-2 -: MU_MAG_W];
        if (mu_mag > MU_CLIP)
            mu_mag = MU_CLIP;
        mu_val = mu_mag + MU_BIAS;
    end

    // Segment search: the highest set bit wins
    always_comb begin
        a_seg  = '0;
        a_mant = a_mag[4:1];
        for (int k = 1; k < 8; k++) begin
            if (a_mag[k+4]) begin
                a_seg  = 3'(k);
                a_mant = a_mag[k+3 -: 4];
            end
        end
    end

    always_comb begin
        mu_seg  = '0;
        mu_mant = mu_val[4:1];
        for (int k = 1; k < 8; k++) begin
            if (mu_val[k+5]) begin
                mu_seg  = 3'(k);
                mu_mant = mu_val[k+4 -: 4];
            end
        end
    end

    always_comb begin
        raw    = law_a ? {pos, a_seg, a_mant} : {pos, mu_seg, mu_mant};
        code_d = raw ^ code_mask(law_e'(law_a), smag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            code_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i)
                code_o <= code_d;
        end
    end
endmodule

// File: rtl/g711_decoder.sv
module g711_decoder
    import g711_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              law_a,
    input  logic              smag,
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              valid_o,
    output logic [LIN_W-1:0]  lin_o
);
    logic [CODE_W-1:0] raw;
    logic              pos;
    logic [2:0]        seg;
    logic [3:0]        mant;
    logic [LIN_W-1:0]  a_mag, mu_mag, mag, lin_d;

    always_comb begin
        raw  = code_i ^ code_mask(law_e'(law_a), smag);
        pos  = raw[7];
        seg  = raw[6:4];
        mant = raw[3:0];
        if (seg == 3'd0)
            a_mag = {8'd0, mant, 4'h8};
        else
            a_mag = {7'd0, 1'b1, mant, 4'h8} << (seg - 3'd1);
        mu_mag = (({9'd0, mant, 3'b000} + MU_DEC_BIAS) << seg) - MU_DEC_BIAS;
        mag    = law_a ? a_mag : mu_mag;
        lin_d  = pos ? mag : (16'd0 - mag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            lin_o   <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i)
                lin_o <= lin_d;
        end
    end
endmodule

// File: rtl/g711_codec.sv
module g711_codec
    import g711_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_law_d,
    input  logic              cfg_smag_d,
    input  logic              law_pin,
    input  logic              enc_valid_i,
    input  logic [LIN_W-1:0]  enc_lin_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic              dec_valid_o,
    output logic [LIN_W-1:0]  dec_lin_o
);
    logic law_q, smag_q, law_eff;

    g711_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .law_d  (cfg_law_d),
        .smag_d (cfg_smag_d),
        .law_q  (law_q),
        .smag_q (smag_q)
    );

    assign law_eff = law_q | law_pin;

    g711_encoder u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .law_a   (law_eff),
        .smag    (smag_q),
        .valid_i (enc_valid_i),
        .lin_i   (enc_lin_i),
        .valid_o (enc_valid_o),
        .code_o  (enc_code_o)
    );

    g711_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .law_a   (law_eff),
        .smag    (smag_q),
        .valid_i (dec_valid_i),
        .code_i  (dec_code_i),
        .valid_o (dec_valid_o),
        .lin_o   (dec_lin_o)
    );
endmodule

// File: rtl/g711_codec_chk.sv
module g711_codec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        law_eff,
    input logic        smag_q,
    input logic        enc_valid_i,
    input logic [15:0] enc_lin_i,
    input logic        enc_valid_o,
    input logic [7:0]  enc_code_o,
    input logic        dec_valid_i,
    input logic [7:0]  dec_code_i,
    input logic        dec_valid_o,
    input logic [15:0] dec_lin_o
);
    p_enc_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o);
    p_enc_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> (!enc_valid_o && $stable(enc_code_o)));
    p_dec_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);
    p_dec_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> (!dec_valid_o && $stable(dec_lin_o)));
    p_true_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid_i && !enc_lin_i[15]) |=> enc_code_o[7]);
    p_a_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid_i && law_eff && !smag_q && enc_lin_i == 16'h0000) |=> enc_code_o == 8'hD5);
    p_mu_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid_i && !law_eff && !smag_q && enc_lin_i == 16'h0000) |=> enc_code_o == 8'hFF);
    p_smag_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid_i && smag_q && enc_lin_i == 16'h0000) |=> enc_code_o == 8'h80);
    p_dec_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && dec_code_i[7]) |=> !dec_lin_o[15]);
    p_dec_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && !dec_code_i[7]) |=> (dec_lin_o[15] || dec_lin_o == 16'h0000));
endmodule

bind g711_codec g711_codec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .law_eff     (law_eff),
    .smag_q      (smag_q),
    .enc_valid_i (enc_valid_i),
    .enc_lin_i   (enc_lin_i),
    .enc_valid_o (enc_valid_o),
    .enc_code_o  (enc_code_o),
    .dec_valid_i (dec_valid_i),
    .dec_code_i  (dec_code_i),
    .dec_valid_o (dec_valid_o),
    .dec_lin_o   (dec_lin_o)
);

// File: tb/g711_codec_tb.sv
module g711_codec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_law_d = 1'b0, cfg_smag_d = 1'b0, law_pin = 1'b0;
    logic        enc_valid_i = 1'b0, dec_valid_i = 1'b0;
    logic [15:0] enc_lin_i = '0;
    logic [7:0]  dec_code_i = '0;
    logic        enc_valid_o, dec_valid_o;
    logic [7:0]  enc_code_o;
    logic [15:0] dec_lin_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    g711_codec u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_law_d(cfg_law_d),
        .cfg_smag_d(cfg_smag_d), .law_pin(law_pin),
        .enc_valid_i(enc_valid_i), .enc_lin_i(enc_lin_i),
        .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
        .dec_valid_o(dec_valid_o), .dec_lin_o(dec_lin_o)
    );

    // {law, smag, is_enc, input[15:0], expected[15:0], req[3:0]}
    localparam int NV = 21;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b1, 16'h0000, 16'h00FF, 4'd6},  // R6
        {1'b1, 1'b0, 1'b1, 16'h0000, 16'h00D5, 4'd5},  // R5
        {1'b0, 1'b0, 1'b1, 16'h7FFF, 16'h0080, 4'd3},  // R3
        {1'b0, 1'b0, 1'b1, 16'h8000, 16'h0000, 4'd3},  // R3
        {1'b0, 1'b0, 1'b1, 16'h7F7C, 16'h0080, 4'd3},  // R3 saturation
        {1'b0, 1'b0, 1'b1, 16'h03E8, 16'h00CE, 4'd3},  // R3
        {1'b0, 1'b0, 1'b1, 16'hFFFF, 16'h007F, 4'd6},  // R6
        {1'b1, 1'b0, 1'b1, 16'h7FFF, 16'h00AA, 4'd4},  // R4
        {1'b1, 1'b0, 1'b1, 16'h8000, 16'h002A, 4'd4},  // R4
        {1'b1, 1'b0, 1'b1, 16'h03E8, 16'h00FA, 4'd4},  // R4
        {1'b1, 1'b0, 1'b1, 16'hFFFF, 16'h0055, 4'd5},  // R5
        {1'b0, 1'b1, 1'b1, 16'h0000, 16'h0080, 4'd7},  // R7
        {1'b1, 1'b1, 1'b1, 16'h0000, 16'h0080, 4'd7},  // R7
        {1'b1, 1'b1, 1'b1, 16'h03E8, 16'h00AF, 4'd7},  // R7
        {1'b0, 1'b0, 1'b0, 16'h00FF, 16'h0000, 4'd8},  // R8
        {1'b1, 1'b0, 1'b0, 16'h00D5, 16'h0008, 4'd8},  // R8
        {1'b0, 1'b0, 1'b0, 16'h0080, 16'h7D7C, 4'd8},  // R8
        {1'b1, 1'b0, 1'b0, 16'h00AA, 16'h7E00, 4'd8},  // R8
        {1'b0, 1'b0, 1'b0, 16'h0000, 16'h8284, 4'd8},  // R8
        {1'b1, 1'b1, 1'b0, 16'h0000, 16'hFFF8, 4'd8},  // R8
        {1'b0, 1'b1, 1'b0, 16'h00B1, 16'h03DC, 4'd8}   // R8
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic law, input logic smag);
        @(negedge clk);
        cfg_we = 1'b1; cfg_law_d = law; cfg_smag_d = smag;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic enc(input logic [15:0] x);
        @(negedge clk);
        enc_valid_i = 1'b1; enc_lin_i = x;
        @(negedge clk);
        enc_valid_i = 1'b0;
    endtask

    task automatic dec(input logic [7:0] c);
        @(negedge clk);
        dec_valid_i = 1'b1; dec_code_i = c;
        @(negedge clk);
        dec_valid_i = 1'b0;
    endtask

    initial begin
        logic [7:0]  mask, exp_code, held8;
        logic [15:0] held16;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 enc_valid_o in reset", {15'd0, enc_valid_o}, 16'd0);
        chk("R1 dec_valid_o in reset", {15'd0, dec_valid_o}, 16'd0);
        chk("R1 enc_code_o in reset", {8'd0, enc_code_o}, 16'd0);
        chk("R1 dec_lin_o in reset", dec_lin_o, 16'd0);
        rst_n = 1'b1;
        enc(16'h0000);
        chk("R1 default mu-law line code of 0", {8'd0, enc_code_o}, 16'h00FF);

        // Table of vectors
        for (int i = 0; i < NV; i++) begin
            set_cfg(VEC[i][38], VEC[i][37]);
            if (VEC[i][36]) begin
                enc(VEC[i][35:20]);
                chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), {8'd0, enc_code_o}, VEC[i][19:4]);
            end else begin
                dec(VEC[i][27:20]);
                chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), dec_lin_o, VEC[i][19:4]);
            end
        end

        // R2: pin ORed with register bit
        set_cfg(1'b0, 1'b0);
        law_pin = 1'b1;
        enc(16'h0000);
        chk("R2 pin selects A-law", {8'd0, enc_code_o}, 16'h00D5);
        dec(8'hD5);
        chk("R2 pin selects A-law decode", dec_lin_o, 16'h0008);
        law_pin = 1'b0;

        // R12: write and sample on the same edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_law_d = 1'b1; cfg_smag_d = 1'b0;
        enc_valid_i = 1'b1; enc_lin_i = 16'h0000;
        @(negedge clk);
        chk("R12 same-cycle sample uses old law", {8'd0, enc_code_o}, 16'h00FF);
        cfg_we = 1'b0;
        @(negedge clk);
        enc_valid_i = 1'b0;
        chk("R12 next sample uses new law", {8'd0, enc_code_o}, 16'h00D5);

        // R9: encoder holds without valid
        enc(16'h03E8);
        held8 = enc_code_o;
        @(negedge clk);
        enc_lin_i = 16'h7FFF;
        @(negedge clk);
        chk("R9 enc_valid_o idle", {15'd0, enc_valid_o}, 16'd0);
        chk("R9 enc_code_o held", {8'd0, enc_code_o}, {8'd0, held8});

        // R10: decoder holds without valid
        dec(8'hAA);
        held16 = dec_lin_o;
        chk("R10 dec_valid_o after strobe", {15'd0, dec_valid_o}, 16'd1);
        @(negedge clk);
        dec_code_i = 8'h00;
        @(negedge clk);
        chk("R10 dec_valid_o idle", {15'd0, dec_valid_o}, 16'd0);
        chk("R10 dec_lin_o held", dec_lin_o, held16);

        // R11: every code, every setting, decoded then re-encoded
        for (int l = 0; l < 2; l++) begin
            for (int s = 0; s < 2; s++) begin
                set_cfg(l[0], s[0]);
                mask = s[0] ? 8'h00 : (l[0] ? 8'h55 : 8'h7F);
                for (int c = 0; c < 256; c++) begin
                    dec(c[7:0]);
                    enc(dec_lin_o);
                    exp_code = c[7:0];
                    if (!l[0] && ((c[7:0] ^ mask) == 8'h00))
                        exp_code = 8'h80 ^ mask;
                    chk($sformatf("R11 law=%0d smag=%0d code=%h", l, s, c[7:0]),
                        {8'd0, enc_code_o}, {8'd0, exp_code});
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule